// File: doc/BRIEF.md
# I2C EEPROM Transfer Sequencer

This block turns one byte-range request against a serial EEPROM into the series of I2C transactions the memory needs. A request carries a 19-bit byte address, a byte count, a direction and an optional cap on the length of any one bus transaction. The block issues byte-level commands (START, byte write, byte read, STOP) to a separate I2C byte master and waits for each command's response. Write data is pulled from an input byte stream and read data is pushed out on an output byte stream.

The three top address bits go into the device address byte. The low sixteen bits are sent as two offset bytes at the head of every transaction. Writes never cross a 256-byte page. Every page write is followed by a fixed self-timed programming delay. When a length cap is given, the cap counts the two offset bytes. The request is first cut into pieces that fit the cap, and page splitting is then applied inside each piece. When the request ends, the block pulses a completion flag together with a byte count and an error code.

Top module: `ee_xfer_seq`

## Requirements
- R1: While reset is held, and after it is released, the block is idle. busy_o, cmd_valid_o, wr_ready_o and done_o are all low.
- R2: Each transaction opens with START. Next comes the device byte {1010, addr[18:16], 0}, then the offset high byte addr[15:8], then the offset low byte addr[7:0] of the chunk's first byte. Bytes land at their linear 19-bit addresses.
- R3: In a write, each chunk is min(bytes left in the piece, 256 - addr[7:0]) bytes long and ends with STOP. No transaction writes past the end of a 256-byte page.
- R4: A read places all of the piece's bytes in one transaction. The sequence is START, device byte, offset bytes, repeated START, device byte with bit 0 = 1, then reads, then STOP. cmd_ack_o is 1 on every read except the last, where it is 0.
- R5: After the STOP of each successful write chunk, at least WAIT_CYC = CLK_FREQ_HZ/1e6*WR_WAIT_US cycles pass before the next fresh START or before done_o.
- R6: A cap L greater than 2 splits the request into pieces of min(L-2, bytes left). The address advances by each piece length, so the number of transactions equals the count from that rule.
- R7: A cap of 1 or 2 ends the request with err_code_o = 3, with no command issued.
- R8: A byte count of zero ends the request with err_code_o = 0 and xfer_cnt_o = 0, with no command issued.
- R9: A NACK on a device byte or an offset byte ends the request with err_code_o = 1. STOP is issued first, and no further START follows.
- R10: A NACK on a write data byte ends the request with err_code_o = 2. xfer_cnt_o then counts only the data bytes that were ACKed.
- R11: A successful request ends with a one-cycle done_o, err_o = 0 and xfer_cnt_o equal to the byte count. Write bytes are used in stream order and read bytes are delivered in address order.
- R12: While cmd_valid_o is high and cmd_ready_i is low, the command and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | Start pulse, sampled only when idle |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_addr_i | input | 19 | First byte address |
| req_len_i | input | LEN_W | Byte count |
| req_limit_i | input | LEN_W | Per-transaction cap including the two offset bytes; 0 = none |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request failed |
| err_code_o | output | 2 | 0 ok, 1 address NACK, 2 data NACK, 3 bad cap |
| xfer_cnt_o | output | LEN_W | Data bytes moved |
| cmd_valid_o | output | 1 | Command to byte master valid |
| cmd_ready_i | input | 1 | Byte master takes command |
| cmd_op_o | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_byte_o | output | 8 | Byte for WRITE |
| cmd_ack_o | output | 1 | For READ: 1 send ACK, 0 send NACK |
| rsp_valid_i | input | 1 | Command finished |
| rsp_nack_i | input | 1 | Slave NACKed a WRITE |
| rsp_byte_i | input | 8 | Byte from READ |
| wr_valid_i | input | 1 | Write stream byte valid |
| wr_ready_o | output | 1 | Write stream byte taken |
| wr_data_i | input | 8 | Write stream byte |
| rd_valid_o | output | 1 | Read stream byte valid |
| rd_data_o | output | 8 | Read stream byte |

## Verification
The bench models an EEPROM that wraps its write pointer inside the page. A chunk length or an address that is computed wrong therefore shows up as wrong bytes on a later read-back, and as a mismatch in the number of fresh STARTs once the request is done. A wrong piece or remaining count appears as an early or late completion flag, and as a byte count that differs from the request. A wait counter that is cut short appears within one transaction as a START that comes too soon after the previous write's STOP. A slip in the read ACK sequence is caught at the STOP that closes the read.

// File: rtl/ee_xfer_pkg.sv
package ee_xfer_pkg;
  localparam int ADDR_W = 19;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_ADDR_NACK = 2'd1,
    ERR_DATA_NACK = 2'd2,
    ERR_BAD_LIMIT = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHUNK, ST_START, ST_DEVW, ST_OFFH, ST_OFFL, ST_WFETCH,
    ST_WDATA, ST_RSTART, ST_DEVR, ST_RDATA, ST_STOP, ST_WAIT
  } st_e;
endpackage

// File: rtl/ee_chunk_calc.sv
module ee_chunk_calc #(
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic                 rd_i,
  input  logic [PAGE_BITS-1:0] addr_lo_i,
  input  logic [LEN_W-1:0]     rem_i,
  input  logic [LEN_W-1:0]     piece_i,
  input  logic [LEN_W-1:0]     limit_i,
  output logic [LEN_W-1:0]     piece_o,
  output logic [LEN_W-1:0]     len_o
);
  localparam logic [LEN_W-1:0] PAGE = LEN_W'(1) << PAGE_BITS;

  logic [LEN_W-1:0] cap, room;
  assign cap  = limit_i - LEN_W'(2);
  assign room = PAGE - LEN_W'(addr_lo_i);

  always_comb begin
    if (limit_i == '0)      piece_o = rem_i;
    else if (piece_i == '0) piece_o = (cap < rem_i) ? cap : rem_i;
    else                    piece_o = piece_i;
    len_o = (!rd_i && room < piece_o) ? room : piece_o;
  end
endmodule

// File: rtl/ee_wait_timer.sv
module ee_wait_timer #(
  parameter int unsigned CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  p_wait_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/ee_xfer_seq.sv
module ee_xfer_seq
  import ee_xfer_pkg::*;
#(
  parameter int          LEN_W       = 16,
  parameter int          PAGE_BITS   = 8,
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned WR_WAIT_US  = 10_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_start_i,
  input  logic              req_read_i,
  input  logic [18:0]       req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [LEN_W-1:0]  req_limit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic [LEN_W-1:0]  xfer_cnt_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [7:0]        cmd_byte_o,
  output logic              cmd_ack_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_nack_i,
  input  logic [7:0]        rsp_byte_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [7:0]        wr_data_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned WAIT_CYC = CLK_FREQ_HZ / 1_000_000 * WR_WAIT_US;
  localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(1) << PAGE_BITS;

  st_e               state_q;
  logic              pend_q, rd_q, fail_q, done_q, rdv_q;
  logic [1:0]        err_q, fail_code_q;
  logic [ADDR_W-1:0] addr_q, cur_q;
  logic [LEN_W-1:0]  lim_q, rem_q, piece_q, chunk_q, cnt_q;
  logic [7:0]        wbyte_q, rdata_q;

  logic [LEN_W-1:0]  piece_eff, chunk_len;
  logic              rsp_fire, tmr_start, tmr_busy, last_byte;

  ee_chunk_calc #(.LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)) u_chunk (
    .rd_i      (rd_q),
    .addr_lo_i (addr_q[PAGE_BITS-1:0]),
    .rem_i     (rem_q),
    .piece_i   (piece_q),
    .limit_i   (lim_q),
    .piece_o   (piece_eff),
    .len_o     (chunk_len)
  );

  assign rsp_fire  = pend_q && rsp_valid_i;
  assign last_byte = (chunk_q == LEN_W'(1));
  assign tmr_start = (state_q == ST_STOP) && rsp_fire && !fail_q && !rd_q;

  ee_wait_timer #(.CYCLES(WAIT_CYC)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .busy_o  (tmr_busy)
  );

  // command presented to the byte master
  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_op_o    = OP_START;
    cmd_byte_o  = 8'h00;
    cmd_ack_o   = 1'b1;
    unique case (state_q)
      ST_START, ST_RSTART: cmd_valid_o = !pend_q;
      ST_DEVW: begin
        cmd_valid_o = !pend_q; cmd_op_o = OP_WRITE;
        cmd_byte_o  = {DEV_TYPE, cur_q[18:16], 1'b0};
      end
      ST_DEVR: begin
        cmd_valid_o = !pend_q; cmd_op_o = OP_WRITE;
        cmd_byte_o  = {DEV_TYPE, cur_q[18:16], 1'b1};
      end
      ST_OFFH: begin
        cmd_valid_o = !pend_q; cmd_op_o = OP_WRITE; cmd_byte_o = cur_q[15:8];
      end
      ST_OFFL: begin
        cmd_valid_o = !pend_q; cmd_op_o = OP_WRITE; cmd_byte_o = cur_q[7:0];
      end
      ST_WDATA: begin
        cmd_valid_o = !pend_q; cmd_op_o = OP_WRITE; cmd_byte_o = wbyte_q;
      end
      ST_RDATA: begin
        cmd_valid_o = !pend_q; cmd_op_o = OP_READ; cmd_ack_o = !last_byte;
      end
      ST_STOP: begin
        cmd_valid_o = !pend_q; cmd_op_o = OP_STOP;
      end
      default: ;
    endcase
  end

  assign wr_ready_o = (state_q == ST_WFETCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; pend_q <= 1'b0; rd_q <= 1'b0; fail_q <= 1'b0;
      done_q <= 1'b0; rdv_q <= 1'b0; err_q <= ERR_NONE; fail_code_q <= ERR_NONE;
      addr_q <= '0; cur_q <= '0; lim_q <= '0; rem_q <= '0; piece_q <= '0;
      chunk_q <= '0; cnt_q <= '0; wbyte_q <= '0; rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      if (cmd_valid_o && cmd_ready_i) pend_q <= 1'b1;
      if (rsp_fire)                   pend_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_start_i) begin
          rd_q <= req_read_i; lim_q <= req_limit_i; addr_q <= req_addr_i;
          rem_q <= req_len_i; piece_q <= '0; cnt_q <= '0; fail_q <= 1'b0;
          err_q <= ERR_NONE;
          if (req_len_i == '0) begin
            done_q <= 1'b1;
          end else if (req_limit_i != '0 && req_limit_i <= LEN_W'(2)) begin
            err_q <= ERR_BAD_LIMIT; done_q <= 1'b1;
          end else begin
            state_q <= ST_CHUNK;
          end
        end
        ST_CHUNK: begin
          cur_q   <= addr_q;
          chunk_q <= chunk_len;
          rem_q   <= rem_q - chunk_len;
          addr_q  <= addr_q + ADDR_W'(chunk_len);
          piece_q <= (lim_q != '0) ? piece_eff - chunk_len : '0;
          state_q <= ST_START;
        end
        ST_START:  if (rsp_fire) state_q <= ST_DEVW;
        ST_RSTART: if (rsp_fire) state_q <= ST_DEVR;
        ST_DEVW, ST_OFFH, ST_OFFL, ST_DEVR: if (rsp_fire) begin
          if (rsp_nack_i) begin
            fail_q <= 1'b1; fail_code_q <= ERR_ADDR_NACK; state_q <= ST_STOP;
          end else if (state_q == ST_DEVW) state_q <= ST_OFFH;
          else if (state_q == ST_OFFH)     state_q <= ST_OFFL;
          else if (state_q == ST_DEVR)     state_q <= ST_RDATA;
          else                             state_q <= rd_q ? ST_RSTART : ST_WFETCH;
        end
        ST_WFETCH: if (wr_valid_i) begin
          wbyte_q <= wr_data_i; state_q <= ST_WDATA;
        end
        ST_WDATA: if (rsp_fire) begin
          if (rsp_nack_i) begin
            fail_q <= 1'b1; fail_code_q <= ERR_DATA_NACK; state_q <= ST_STOP;
          end else begin
            cnt_q <= cnt_q + LEN_W'(1); chunk_q <= chunk_q - LEN_W'(1);
            state_q <= last_byte ? ST_STOP : ST_WFETCH;
          end
        end
        ST_RDATA: if (rsp_fire) begin
          rdv_q <= 1'b1; rdata_q <= rsp_byte_i;
          cnt_q <= cnt_q + LEN_W'(1); chunk_q <= chunk_q - LEN_W'(1);
          if (last_byte) state_q <= ST_STOP;
        end
        ST_STOP: if (rsp_fire) begin
          if (fail_q) begin
            err_q <= fail_code_q; done_q <= 1'b1; state_q <= ST_IDLE;
          end else if (!rd_q) begin
            state_q <= ST_WAIT;
          end else if (rem_q == '0) begin
            done_q <= 1'b1; state_q <= ST_IDLE;
          end else begin
            state_q <= ST_CHUNK;
          end
        end
        ST_WAIT: if (!tmr_busy) begin
          if (rem_q == '0) begin
            done_q <= 1'b1; state_q <= ST_IDLE;
          end else begin
            state_q <= ST_CHUNK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_code_o = err_q;
  assign err_o      = (err_q != ERR_NONE);
  assign xfer_cnt_o = cnt_q;
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rdata_q;

  p_cmd_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_byte_o) && $stable(cmd_ack_o)));

  p_page_fit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHUNK && !rd_q) |->
      (chunk_len + LEN_W'(addr_q[PAGE_BITS-1:0]) <= PAGE_LEN));

  p_piece_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHUNK && lim_q != '0) |->
      (chunk_len != '0 && chunk_len <= lim_q - LEN_W'(2)));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_no_cmd_in_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tmr_busy) |-> !cmd_valid_o);
endmodule

// File: tb/ee_xfer_seq_tb.sv
module ee_xfer_seq_tb;
  import ee_xfer_pkg::*;
  localparam int LW   = 16;
  localparam int WAIT = 30;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, req_start_i, req_read_i;
  logic [18:0] req_addr_i;
  logic [LW-1:0] req_len_i, req_limit_i, xfer_cnt_o;
  logic busy_o, done_o, err_o, cmd_valid_o, cmd_ready_i, cmd_ack_o;
  logic [1:0] err_code_o, cmd_op_o;
  logic [7:0] cmd_byte_o, rsp_byte_i, wr_data_i, rd_data_o;
  logic rsp_valid_i, rsp_nack_i, wr_valid_i, wr_ready_o, rd_valid_o;

  ee_xfer_seq #(.LEN_W(LW), .PAGE_BITS(8), .CLK_FREQ_HZ(1_000_000), .WR_WAIT_US(WAIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_start_i(req_start_i), .req_read_i(req_read_i),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i), .req_limit_i(req_limit_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
    .xfer_cnt_o(xfer_cnt_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_op_o(cmd_op_o), .cmd_byte_o(cmd_byte_o), .cmd_ack_o(cmd_ack_o),
    .rsp_valid_i(rsp_valid_i), .rsp_nack_i(rsp_nack_i), .rsp_byte_i(rsp_byte_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model state
  logic [7:0] smem [int];
  logic [7:0] rmem [int];
  logic [7:0] wq[$];
  logic [7:0] rq[$];
  int n_starts, byte_idx, nack_at, last_wstop = -100000;
  int viol_page, viol_ack, viol_wait, viol_dev, viol_hold;
  int first_dev;
  bit in_txn, txn_rd, expect_dev, last_zero, txn_nacked;
  int offs_n, wcnt, rcnt, dev, ptr;
  logic [15:0] off;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mrd(int a);
    return smem.exists(a) ? smem[a] : 8'h00;
  endfunction

  function automatic logic [7:0] rref(int a);
    return rmem.exists(a) ? rmem[a] : 8'h00;
  endfunction

  function automatic int exp_txn(int a, int n, bit rd, int lim);
    int t = 0;
    int cap = (lim == 0) ? n : lim - 2;
    while (n > 0) begin
      int p = (cap < n) ? cap : n;
      int b = a;
      int r = p;
      while (r > 0) begin
        int room = 256 - (b % 256);
        int c = (rd || r < room) ? r : room;
        t++; b += c; r -= c;
      end
      a += p; n -= p;
    end
    return t;
  endfunction

  task automatic model(input logic [1:0] op, input logic [7:0] b, input logic ak,
                       output logic nk, output logic [7:0] rdat, output bit wstop);
    nk = 1'b0; rdat = 8'h00; wstop = 1'b0;
    case (op)
      OP_START: begin
        if (!in_txn) begin
          n_starts++;
          if (cyc - last_wstop < WAIT) viol_wait++;
          in_txn = 1; txn_rd = 0; offs_n = 0; wcnt = 0; rcnt = 0;
          txn_nacked = 0; last_zero = 0;
        end
        expect_dev = 1;
      end
      OP_WRITE: begin
        nk = (byte_idx == nack_at);
        byte_idx++;
        if (nk) txn_nacked = 1;
        if (expect_dev) begin
          if (b[7:4] != 4'b1010) viol_dev++;
          if (first_dev < 0) first_dev = int'(b);
          dev = int'(b[3:1]);
          if (b[0]) begin txn_rd = 1; ptr = (dev << 16) | int'(off); end
          expect_dev = 0;
        end else if (offs_n < 2) begin
          if (offs_n == 0) off[15:8] = b; else off[7:0] = b;
          offs_n++;
        end else begin
          if (wcnt >= 256 - int'(off[7:0])) viol_page++;
          if (!nk) smem[(dev << 16) | (int'(off[15:8]) << 8) | ((int'(off[7:0]) + wcnt) % 256)] = b;
          wcnt++;
        end
      end
      OP_READ: begin
        if (last_zero) viol_ack++;
        last_zero = !ak;
        rdat = mrd(ptr);
        ptr = (ptr + 1) % 524288;
        rcnt++;
      end
      default: begin
        if (txn_rd && rcnt > 0 && !last_zero) viol_ack++;
        wstop = !txn_rd && wcnt > 0 && !txn_nacked;
        in_txn = 0;
      end
    endcase
  endtask

  // byte master / EEPROM responder
  initial begin
    logic [1:0] op; logic [7:0] b, rdat; logic ak, nk; bit ws;
    logic pv; logic [1:0] pop; logic [7:0] pb; logic pa;
    void'($urandom(32'd1234));
    cmd_ready_i = 0; rsp_valid_i = 0; rsp_nack_i = 0; rsp_byte_i = 0; pv = 0;
    pop = 0; pb = 0; pa = 0;
    forever begin
      @(negedge clk);
      rsp_valid_i = 0; rsp_nack_i = 0;
      if (pv && !(cmd_valid_o && cmd_op_o == pop && cmd_byte_o == pb && cmd_ack_o == pa))
        viol_hold++;
      cmd_ready_i = ($urandom % 3) != 0;
      pv = cmd_valid_o && !cmd_ready_i;
      pop = cmd_op_o; pb = cmd_byte_o; pa = cmd_ack_o;
      if (cmd_valid_o && cmd_ready_i) begin
        op = cmd_op_o; b = cmd_byte_o; ak = cmd_ack_o;
        model(op, b, ak, nk, rdat, ws);
        @(negedge clk);
        cmd_ready_i = 0;
        repeat ($urandom % 3) @(negedge clk);
        rsp_valid_i = 1; rsp_nack_i = nk; rsp_byte_i = rdat;
        if (ws) last_wstop = cyc;
      end
    end
  end

  // write stream source
  initial begin
    wr_valid_i = 0; wr_data_i = 0;
    forever begin
      @(negedge clk);
      if (wq.size() > 0 && ($urandom % 4) != 0) begin
        wr_valid_i = 1; wr_data_i = wq[0];
      end else wr_valid_i = 0;
      if (wr_valid_i && wr_ready_o) begin
        @(posedge clk);
        void'(wq.pop_front());
      end
    end
  end

  // read stream sink
  initial forever begin
    @(negedge clk);
    if (rd_valid_o) rq.push_back(rd_data_o);
  end

  task automatic do_req(int a, int n, bit rd, int lim, int nk_at, int exp_err, string tag);
    logic [7:0] wd[$];
    int t = 0, e_starts;
    int vp = viol_page, va = viol_ack, vw = viol_wait, vd = viol_dev;
    wq.delete(); rq.delete(); wd.delete();
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = 8'($urandom);
      wd.push_back(v);
      if (!rd) wq.push_back(v);
    end
    n_starts = 0; byte_idx = 0; nack_at = nk_at; first_dev = -1;
    @(negedge clk);
    req_addr_i = 19'(a); req_len_i = LW'(n); req_read_i = rd;
    req_limit_i = LW'(lim); req_start_i = 1;
    @(negedge clk);
    req_start_i = 0;
    while (!done_o && t < 60000) begin @(negedge clk); t++; end
    chk(done_o == 1'b1, {tag, " done"}, int'(done_o), 1);
    chk(int'(err_code_o) == exp_err, {tag, " err_code"}, int'(err_code_o), exp_err);
    chk(err_o == (exp_err != 0), {tag, " err_o"}, int'(err_o), int'(exp_err != 0));
    if (exp_err == 0) begin
      e_starts = exp_txn(a, n, rd, lim);
      chk(int'(xfer_cnt_o) == n, "R11 count", int'(xfer_cnt_o), n);
      chk(n_starts == e_starts, {tag, " R6 transactions"}, n_starts, e_starts);
      chk(viol_page == vp, "R3 page overrun", viol_page - vp, 0);
      chk(viol_dev == vd, "R2 device type", viol_dev - vd, 0);
      chk(viol_wait == vw, "R5 write wait gap", viol_wait - vw, 0);
      if (rd) begin
        chk(viol_ack == va, "R4 ack pattern", viol_ack - va, 0);
        chk(rq.size() == n, "R11 read byte count", rq.size(), n);
        for (int i = 0; i < n && i < rq.size(); i++)
          if (rq[i] != rref((a + i) % 524288)) begin
            chk(0, "R11 read data", int'(rq[i]), int'(rref((a + i) % 524288)));
            break;
          end
      end else if (n > 0) begin
        chk(cyc - last_wstop >= WAIT, "R5 wait before done", cyc - last_wstop, WAIT);
        for (int i = 0; i < n; i++) rmem[(a + i) % 524288] = wd[i];
      end
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R11 done one cycle", int'(done_o), 0);
  endtask

  initial begin
    rst_ni = 0; req_start_i = 0; req_read_i = 0; req_addr_i = 0;
    req_len_i = 0; req_limit_i = 0;
    viol_page = 0; viol_ack = 0; viol_wait = 0; viol_dev = 0; viol_hold = 0;
    in_txn = 0; nack_at = -1; off = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !done_o && !wr_ready_o, "R1 reset idle", int'(busy_o), 0);
    rst_ni = 1;
    @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !done_o, "R1 after reset", int'(cmd_valid_o), 0);

    // zero length and invalid caps
    do_req(16'h0100, 0, 0, 0, -1, 0, "R8");
    chk(n_starts == 0 && xfer_cnt_o == 0, "R8 no bus activity", n_starts, 0);
    do_req(16'h0100, 5, 0, 2, -1, 3, "R7");
    chk(n_starts == 0, "R7 no bus activity cap 2", n_starts, 0);
    do_req(16'h0100, 5, 1, 1, -1, 3, "R7");
    chk(n_starts == 0, "R7 no bus activity cap 1", n_starts, 0);

    // page crossing write with high device bits, then one-shot read
    do_req(19'h5_23F0, 40, 0, 0, -1, 0, "R3");
    chk(first_dev == 8'hAA, "R2 device byte", first_dev, 8'hAA);
    do_req(19'h5_2300, 300, 1, 0, -1, 0, "R4");
    chk(n_starts == 1, "R4 single read transaction", n_starts, 1);

    // capped write and read
    do_req(19'h3_00FC, 20, 0, 10, -1, 0, "R6");
    chk(n_starts == 4, "R6 capped write split", n_starts, 4);
    do_req(19'h3_00FC, 20, 1, 5, -1, 0, "R6");
    chk(n_starts == 7, "R6 capped read split", n_starts, 7);

    // NACK cases in an area never read back
    do_req(19'h7_1000, 10, 0, 0, 0, 1, "R9");
    chk(n_starts == 1 && xfer_cnt_o == 0, "R9 stop after device nack", n_starts, 1);
    do_req(19'h7_2000, 10, 1, 0, 1, 1, "R9");
    chk(n_starts == 1, "R9 stop after offset nack", n_starts, 1);
    do_req(19'h7_3000, 10, 0, 0, 4, 2, "R10");
    chk(int'(xfer_cnt_o) == 1, "R10 acked bytes", int'(xfer_cnt_o), 1);

    // random write/read-back pairs
    for (int i = 0; i < 10; i++) begin
      int n = 1 + $urandom % 300;
      int a = $urandom % (32'h70000 - n);
      int l1 = ($urandom % 2) ? 0 : 3 + $urandom % 70;
      int l2 = ($urandom % 2) ? 0 : 3 + $urandom % 70;
      do_req(a, n, 0, l1, -1, 0, "R3");
      do_req(a, n, 1, l2, -1, 0, "R4");
    end
    chk(viol_hold == 0, "R12 command hold", viol_hold, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule